// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store command into the series of byte addresses for its elements, one per cycle. A single start pulse captures the mode, a scalar base address, a signed stride, the element size and the runtime vector length. The block then issues exactly that many addresses over a valid/ready output, each tagged with its element number. When the last address has been accepted, it pulses a done flag.

Three modes share one element counter. In unit mode, consecutive elements are one element width apart. In strided mode, the spacing is a signed number of elements taken from the scalar stride. In indexed mode, each address is the base plus a signed byte offset taken from an index stream, one offset per element and in element order. Indexed mode is used for gathers and scatters.

The memory, the data path and the vector register file lie outside this block.

Top module: `vec_addr_gen`

## Requirements
- R1: With mode 0 (unit), element i is issued at base + i * B, where the element size code `esz_i` 0, 1, 2, 3 gives B = 1, 2, 4, 8 bytes.
- R2: With mode 1 (strided), element i is issued at base + i * stride * B, with `stride_i` read as a two's-complement count of elements. All address arithmetic wraps at ADDR_W bits.
- R3: With mode 2 (indexed), element i is issued at base + idx_i, where idx_i is the i-th word accepted on the index stream (`idx_valid_i` and `idx_ready_o` both high), read as a signed byte offset. `idx_ready_o` is never high outside an indexed sequence.
- R4: A sequence issues exactly min(`vl_i`, MAX_VL) addresses, with MAX_VL = 64. `elem_o` counts 0, 1, 2 and so on, in order.
- R5: Every element size code 0 to 3 scales the address step as stated in R1.
- R6: A vector length of 0 raises `done_o` in the cycle after the start pulse and issues no address.
- R7: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_valid_o`, `addr_o` and `elem_o` hold their values into the next cycle.
- R8: A start pulse that arrives while a sequence is in progress is ignored. The running sequence completes unchanged, and no further addresses follow it.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last address is accepted. `addr_valid_o` is low while `done_o` is high.
- R10: After reset, `addr_valid_o`, `idx_ready_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse that captures the command |
| mode_i | input | 2 | 0 unit, 1 strided, 2 indexed (3 behaves as unit) |
| base_i | input | ADDR_W | Scalar base byte address |
| stride_i | input | ADDR_W | Signed stride in elements |
| esz_i | input | 2 | Element size code: 1, 2, 4 or 8 bytes |
| vl_i | input | VL_W | Vector length, clamped to MAX_VL |
| idx_valid_i | input | 1 | Index word valid |
| idx_data_i | input | ADDR_W | Signed byte offset for the next element |
| idx_ready_o | output | 1 | Index word taken this cycle |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Address accepted by consumer |
| addr_o | output | ADDR_W | Element byte address |
| elem_o | output | EL_W | Element number of `addr_o` |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench pushes a vector length of 0, where a faulty design would never signal done or would emit a stray address. It pushes the clamp above MAX_VL, where a faulty design would issue the wrong number of elements. It drives a negative stride with wide elements, which exposes a zero-extended or unscaled step as wrong addresses. Random stalls on both the index stream and the address output catch a dropped or repeated index, and an address that moves while it is stalled. A second start pulse in mid-sequence must not restart the counter or change the addresses, and a late done pulse or one longer than a single cycle is flagged in the cycle it occurs.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_RSVD   = 2'd3
  } am_e;
endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl #(
  parameter int MAX_VL = 64,
  localparam int VL_W = $clog2(MAX_VL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            load_i,
  input  logic            fire_i,
  output logic            start_ok_o,
  output logic            busy_o,
  output logic            more_o,
  output logic [VL_W-1:0] iss_o,
  output logic            done_o
);
  logic [VL_W-1:0] vl_q, iss_q, acc_q, vl_eff;
  logic [VL_W-1:0] vl_d, iss_d, acc_d;
  logic            busy_q, done_q, busy_d, done_d, last_acc;

  assign vl_eff     = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;
  assign start_ok_o = start_i && !busy_q;
  assign last_acc   = fire_i && (acc_q == vl_q - VL_W'(1));

  always_comb begin
    vl_d   = vl_q;
    iss_d  = iss_q;
    acc_d  = acc_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start_ok_o) begin
      vl_d   = vl_eff;
      iss_d  = '0;
      acc_d  = '0;
      busy_d = (vl_eff != '0);
      done_d = (vl_eff == '0);
    end else if (busy_q) begin
      if (load_i) iss_d = iss_q + VL_W'(1);
      if (fire_i) acc_d = acc_q + VL_W'(1);
      if (last_acc) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q   <= '0;
      iss_q  <= '0;
      acc_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vl_q   <= vl_d;
      iss_q  <= iss_d;
      acc_q  <= acc_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign more_o = busy_q && (iss_q < vl_q);
  assign iss_o  = iss_q;
  assign done_o = done_q;

  // R6: an empty sequence finishes at once
  p_zero_vl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok_o && (vl_eff == '0) |=> done_o && !busy_o);
  // R8: a second start leaves the running length alone
  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !last_acc |=> busy_q && $stable(vl_q));
  // R4: never more issued than the captured length
  p_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_q <= vl_q) && (acc_q <= iss_q));
endmodule

// File: rtl/vag_agu.sv
module vag_agu
  import vag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_ok_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [1:0]        esz_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] idx_i,
  output logic              idx_mode_o,
  output logic [ADDR_W-1:0] addr_o
);
  am_e               mode_q;
  logic [ADDR_W-1:0] base_q, step_q, off_q, step_d;

  // stride is in elements; shift to bytes keeps two's complement sign
  always_comb begin
    unique case (am_e'(mode_i))
      AM_STRIDE: step_d = stride_i << esz_i;
      default:   step_d = ADDR_W'(1) << esz_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= AM_UNIT;
      base_q <= '0;
      step_q <= '0;
      off_q  <= '0;
    end else if (start_ok_i) begin
      mode_q <= am_e'(mode_i);
      base_q <= base_i;
      step_q <= step_d;
      off_q  <= '0;
    end else if (adv_i) begin
      off_q  <= off_q + step_q;
    end
  end

  assign idx_mode_o = (mode_q == AM_INDEX);
  assign addr_o     = base_q + (idx_mode_o ? idx_i : off_q);
endmodule

// File: rtl/vag_outreg.sv
module vag_outreg #(
  parameter int ADDR_W = 32,
  parameter int EL_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EL_W-1:0]   elem_i,
  input  logic              ready_i,
  output logic              space_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [EL_W-1:0]   elem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      elem_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      elem_o  <= elem_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign space_o = !valid_o || ready_i;

  // R7: stalled beat holds
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(elem_o));
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 64,
  localparam int VL_W = $clog2(MAX_VL + 1),
  localparam int EL_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [1:0]        esz_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              idx_valid_i,
  input  logic [ADDR_W-1:0] idx_data_i,
  output logic              idx_ready_o,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [EL_W-1:0]   elem_o,
  output logic              done_o
);
  logic              start_ok, busy, more, space, idx_mode, load, fire, can_go;
  logic [VL_W-1:0]   iss;
  logic [ADDR_W-1:0] next_addr;

  assign can_go      = busy && more && space;
  assign load        = can_go && (!idx_mode || idx_valid_i);
  assign idx_ready_o = can_go && idx_mode;
  assign fire        = addr_valid_o && addr_ready_i;

  vag_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .vl_i,
    .load_i(load), .fire_i(fire), .start_ok_o(start_ok),
    .busy_o(busy), .more_o(more), .iss_o(iss), .done_o(done_o)
  );

  vag_agu #(.ADDR_W(ADDR_W)) u_agu (
    .clk_i, .rst_ni, .start_ok_i(start_ok), .mode_i, .base_i, .stride_i,
    .esz_i, .adv_i(load), .idx_i(idx_data_i),
    .idx_mode_o(idx_mode), .addr_o(next_addr)
  );

  vag_outreg #(.ADDR_W(ADDR_W), .EL_W(EL_W)) u_out (
    .clk_i, .rst_ni, .load_i(load), .addr_i(next_addr),
    .elem_i(iss[EL_W-1:0]), .ready_i(addr_ready_i), .space_o(space),
    .valid_o(addr_valid_o), .addr_o(addr_o), .elem_o(elem_o)
  );

  // R9: done never overlaps an outstanding beat or index request
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !addr_valid_o && !idx_ready_o);
  // R3: index stream only drawn while a sequence runs
  p_idx_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_ready_o |-> busy);
endmodule

// File: tb/sim_vec_addr_gen.sv
module sim_vec_addr_gen;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic          start_i = 0, idx_valid_i = 0, addr_ready_i = 0;
  logic [1:0]    mode_i = 0, esz_i = 0;
  logic [AW-1:0] base_i = 0, stride_i = 0, idx_data_i = 0;
  logic [6:0]    vl_i = 0;
  logic          idx_ready_o, addr_valid_o, done_o;
  logic [AW-1:0] addr_o;
  logic [5:0]    elem_o;

  vec_addr_gen u0 (.clk_i(clk), .rst_ni(rst_n), .start_i, .mode_i, .base_i,
    .stride_i, .esz_i, .vl_i, .idx_valid_i, .idx_data_i, .idx_ready_o,
    .addr_valid_o, .addr_ready_i, .addr_o, .elem_o, .done_o);

  int checks = 0, errors = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference state
  logic [AW-1:0] exp_addr[$];
  logic [AW-1:0] idx_q[$];
  bit   busy_m = 0, done_exp = 0, prev_hold = 0;
  int   nxt_elem = 0, n_exp = 0, cur_mode = 0, rdy_mode = 0;
  string dreq = "R9", areq = "R1";
  logic [AW-1:0] prev_addr;
  logic [5:0]    prev_elem;

  always @(negedge clk) if (rst_n) begin
    chk(done_o == done_exp, dreq, "done_o", done_o, done_exp);
    if (prev_hold) begin
      chk(addr_valid_o && addr_o == prev_addr && elem_o == prev_elem, "R7",
          "stalled beat held", addr_o, prev_addr);
    end
    if (idx_ready_o && !(busy_m && cur_mode == 2))
      chk(0, "R3", "idx_ready_o outside indexed", 1, 0);
    done_exp = 0;
    case (rdy_mode)
      0: addr_ready_i = 1;
      1: addr_ready_i = ($urandom % 2) == 0;
      default: addr_ready_i = ($urandom % 4) == 0;
    endcase
    if (idx_q.size() > 0 && ($urandom % 3) != 0) begin
      idx_valid_i = 1;
      idx_data_i  = idx_q[0];
    end else begin
      idx_valid_i = 0;
      idx_data_i  = $urandom;
    end
    #1;
    if (start_i && !busy_m) begin
      int vl_e;
      int bytes;
      vl_e = (vl_i > 64) ? 64 : int'(vl_i);
      bytes = 1 << esz_i;
      cur_mode = (mode_i == 3) ? 0 : int'(mode_i);
      areq = (cur_mode == 0) ? "R1" : (cur_mode == 1) ? "R2" : "R3";
      nxt_elem = 0;
      n_exp = vl_e;
      if (vl_e == 0) begin
        done_exp = 1;
        dreq = "R6";
      end else busy_m = 1;
      for (int i = 0; i < vl_e; i++) begin
        logic [AW-1:0] ix;
        ix = $urandom;
        if (cur_mode == 2) begin
          idx_q.push_back(ix);
          exp_addr.push_back(base_i + ix);
        end else if (cur_mode == 1)
          exp_addr.push_back(base_i + AW'(i * $signed(stride_i) * bytes));
        else
          exp_addr.push_back(base_i + AW'(i * bytes));
      end
    end
    if (addr_valid_o && addr_ready_i) begin
      if (exp_addr.size() == 0) chk(0, "R4", "extra address", addr_o, 0);
      else begin
        chk(addr_o == exp_addr[0], areq, "addr_o", addr_o, exp_addr[0]);
        chk(elem_o == 6'(nxt_elem), "R4", "elem_o", elem_o, nxt_elem);
        void'(exp_addr.pop_front());
        nxt_elem++;
        if (nxt_elem == n_exp) begin
          busy_m = 0;
          done_exp = 1;
          dreq = "R9";
        end
      end
    end
    if (idx_valid_i && idx_ready_o) void'(idx_q.pop_front());
    prev_hold = addr_valid_o && !addr_ready_i;
    prev_addr = addr_o;
    prev_elem = elem_o;
  end

  task automatic run(input int md, input logic [AW-1:0] b, input int st,
                     input int es, input int vl, input int rm, input string rq);
    @(negedge clk);
    rdy_mode = rm;
    mode_i = 2'(md); base_i = b; stride_i = AW'(st); esz_i = 2'(es);
    vl_i = 7'(vl); start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (busy_m) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_addr.size() == 0, rq, "all addresses issued", exp_addr.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!addr_valid_o && !idx_ready_o && !done_o, "R10", "reset outputs",
        {addr_valid_o, idx_ready_o, done_o}, 0);
    rst_n = 1;
    run(0, 32'h1000, 0, 2, 8, 0, "R1");
    run(0, 32'h2001, 0, 0, 64, 1, "R4");
    run(1, 32'h3000, 3, 3, 10, 1, "R2");
    run(1, 32'h0004, -2, 1, 5, 2, "R2");
    run(3, 32'h4000, 0, 1, 4, 1, "R5");
    run(2, 32'h8000_0000, 0, 2, 12, 1, "R3");
    run(0, 32'h5000, 0, 3, 0, 0, "R6");
    run(1, 32'h6000, 1, 1, 1, 0, "R5");
    run(0, 32'h7000, 0, 0, 100, 1, "R4");
    // R8: restart pulse in mid-sequence
    @(negedge clk);
    rdy_mode = 2;
    mode_i = 1; base_i = 32'h9000; stride_i = 5; esz_i = 2; vl_i = 6;
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (4) @(negedge clk);
    mode_i = 0; base_i = 32'hA000; vl_i = 3; start_i = 1;
    @(negedge clk);
    start_i = 0;
    while (busy_m) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(exp_addr.size() == 0 && !addr_valid_o, "R8", "restart ignored",
        exp_addr.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule